// File: doc/BRIEF.md
# Codec Control Register Command Decoder

This block keeps the small set of configuration registers of a voiceband codec and interprets the 16-bit command words that a serial front end collects during secondary (control) frames. A command either writes one register or reads one back. A read produces a response word in the cycle after the command, so the front end can return it within the same secondary frame. The shifting of serial bits, the frame timing and the analog circuits are handled elsewhere.

The register contents drive the codec's operating modes directly. These are the interpolator/decimator FIR bypass, the analog or digital loopback, the event-monitor mode, the ADC and DAC path shutdowns, software power-down, and the source of the general-purpose flag pin. A decimator overflow event sets a sticky status bit. That bit stays set until software reads it. A write can request a software reset, which returns every register to its default. While the hardware power-down input is active, the block ignores commands and events and keeps all of its state.

Top module: `codec_ctrl_regs`

## Requirements
- R1: A command word uses bit 12 as read (1) or write (0), bits 11:9 as the register address and bits 7:0 as the data. A write to address 2, 3 or 4 stores all eight data bits, and a later read returns them.
- R2: A read makes `rsp_valid` high for exactly the next cycle. `rsp_word` is then {is_master, 2'b00, 1'b1, address, 1'b0, contents}. Addresses 0, 5, 6 and 7 return contents 0. Without a read command, `rsp_valid` stays low.
- R3: A word whose bits 15:9 are all zero is a no-op. It changes no register and produces no response.
- R4: Register 1 bit 7 is set by a pulse on `ovf_event` and stays set until register 1 is read. The read returns the set bit and clears it. If an event arrives in the same cycle as that read, the bit stays set. Writes do not change bit 7.
- R5: Writing register 1 with data bit 3 set restores the defaults (register 2 = 0x20, all other registers 0, overflow bit 0) and makes `soft_rst` high for one cycle. Bit 3 always reads back 0.
- R6: `fir_bypass` follows register 1 bit 2. Register 3 bits 7:6 select the test mode: 01 gives `loop_analog`, 10 gives `loop_digital`, 11 gives `evt_mon`, and 00 selects none of them.
- R7: Any accepted read clears register 3 bits 7:6 when they hold 11 (event-monitor mode). The other bits of register 3 are kept, and the read response shows the value from before the clear.
- R8: Register 3 bits 2:1 give 01 `adc_off`, 10 `dac_off`, 11 `soft_pd`. Register writes are still accepted while `soft_pd` is high.
- R9: `flag_pin` equals `sec_interval` when register 3 bit 4 is 0, and equals register 3 bit 3 when bit 4 is 1.
- R10: While `hw_pd_n` is low, commands and overflow events are ignored and all register contents are kept. No response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| hw_pd_n | input | 1 | Hardware power-down, active low; freezes the block |
| is_master | input | 1 | Master/slave indicator returned in response bit 15 |
| cmd_valid | input | 1 | One-cycle strobe marking a new command word |
| cmd_word | input | 16 | Command word from a secondary frame |
| ovf_event | input | 1 | Decimator overflow pulse |
| sec_interval | input | 1 | High during the secondary communication interval |
| rsp_valid | output | 1 | Response word valid, one cycle after a read |
| rsp_word | output | 16 | Read response word |
| fir_bypass | output | 1 | FIR stages bypassed |
| loop_analog | output | 1 | Analog loopback selected |
| loop_digital | output | 1 | Digital loopback selected |
| evt_mon | output | 1 | Event-monitor mode active |
| adc_off | output | 1 | ADC path turned off |
| dac_off | output | 1 | DAC path turned off |
| soft_pd | output | 1 | Software power-down |
| flag_pin | output | 1 | General-purpose flag pin value |
| soft_rst | output | 1 | One-cycle pulse after a software reset |

## Verification
The bench writes every data value to every register and reads each one back. This sweep catches any field that is wrongly masked or wrongly stored, and covers every test-mode and path code together with the flag source select. The bench also targets the cases that are easy to get wrong. A read of register 1 in the same cycle as an overflow event must not lose the event, and a design that let the clear win would drop it. A read must end event-monitor mode, and a design that only cleared it on reads of register 3 would leave `evt_mon` high. Words with bits 15:9 zero are swept with bit 8 and the data bits varied, so a decoder that looked at bit 8 or the data would wrongly act on them. Commands and events are also applied while `hw_pd_n` is low, and a design that did not gate them would change its contents.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;
    localparam int CMD_W    = 16;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 5;

    // field positions inside a command word
    localparam int RD_BIT    = 12;
    localparam int ADDR_LSB  = 9;
    localparam int NOOP_LSB  = 9;

    // register indices and bit positions the modes depend on
    localparam logic [ADDR_W-1:0] REG_CTRL1 = 3'd1;
    localparam logic [ADDR_W-1:0] REG_RATE  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_MODE  = 3'd3;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
    localparam int OVF_BIT   = 7;
    localparam int SRST_BIT  = 3;
    localparam int FIRBY_BIT = 2;
    localparam int TEST_HI   = 7;
    localparam int TEST_LO   = 6;
    localparam int FSRC_BIT  = 4;
    localparam int FVAL_BIT  = 3;
    localparam int PATH_HI   = 2;
    localparam int PATH_LO   = 1;
    localparam logic [DATA_W-1:0] RATE_DEFAULT = 8'h20;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] regs_t;

    function automatic regs_t default_regs();
        regs_t r;
        for (int i = 0; i < NUM_REGS; i++) begin
            r[i] = (i == int'(REG_RATE)) ? RATE_DEFAULT : '0;
        end
        return r;
    endfunction
endpackage

// File: rtl/ctrl_cmd_decode.sv
module ctrl_cmd_decode
    import codec_ctrl_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              en,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic noop;
    logic unused_spare;

    always_comb begin
        noop         = (cmd_word[CMD_W-1:NOOP_LSB] == '0);
        addr         = cmd_word[ADDR_LSB +: ADDR_W];
        data         = cmd_word[DATA_W-1:0];
        rd_en        = cmd_valid && en && cmd_word[RD_BIT];
        wr_en        = cmd_valid && en && !cmd_word[RD_BIT] && !noop;
        unused_spare = cmd_word[DATA_W];
    end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import codec_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf_event,
    input  logic              is_master,
    output regs_t             regs,
    output logic              rsp_valid,
    output logic [CMD_W-1:0]  rsp_word,
    output logic              soft_rst
);
    typedef struct packed {
        regs_t            regs;
        logic             ovf;
        logic             rsp_valid;
        logic [CMD_W-1:0] rsp_word;
        logic             srst;
    } state_t;

    state_t state_d, state_q;
    logic              in_range;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] wval;

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        state_d.srst      = 1'b0;
        in_range          = (addr != '0) && (addr <= LAST_ADDR);
        rdata             = in_range ? state_q.regs[addr] : '0;
        if (addr == REG_CTRL1) rdata[OVF_BIT] = state_q.ovf;
        wval = wdata;
        if (addr == REG_CTRL1) begin
            wval[OVF_BIT]  = 1'b0;
            wval[SRST_BIT] = 1'b0;
        end

        if (en && ovf_event) state_d.ovf = 1'b1;

        if (wr_en) begin
            if (addr == REG_CTRL1 && wdata[SRST_BIT]) begin
                state_d.regs = default_regs();
                state_d.ovf  = 1'b0;
                state_d.srst = 1'b1;
            end else if (in_range) begin
                state_d.regs[addr] = wval;
            end
        end

        if (rd_en) begin
            state_d.rsp_valid = 1'b1;
            state_d.rsp_word  = {is_master, 2'b00, 1'b1, addr, 1'b0, rdata};
            if (addr == REG_CTRL1 && !ovf_event) state_d.ovf = 1'b0;
            if (state_q.regs[REG_MODE][TEST_HI:TEST_LO] == 2'b11)
                state_d.regs[REG_MODE][TEST_HI:TEST_LO] = 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.regs      <= default_regs();
            state_q.ovf       <= 1'b0;
            state_q.rsp_valid <= 1'b0;
            state_q.rsp_word  <= '0;
            state_q.srst      <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign regs      = state_q.regs;
    assign rsp_valid = state_q.rsp_valid;
    assign rsp_word  = state_q.rsp_word;
    assign soft_rst  = state_q.srst;

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ovf && !(rd_en && addr == REG_CTRL1)
            && !(wr_en && addr == REG_CTRL1 && wdata[SRST_BIT]) |=> state_q.ovf);

    assert_ovf_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == REG_CTRL1 && !ovf_event |=> !state_q.ovf);

    assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == REG_CTRL1 && wdata[SRST_BIT]
            |=> soft_rst && !state_q.ovf && state_q.regs == default_regs());

    assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid && rsp_word[RD_BIT]);

    assert_no_rsp_without_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);

    assert_read_ends_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> state_q.regs[REG_MODE][TEST_HI:TEST_LO] != 2'b11);

    assert_hold_in_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q.regs) && $stable(state_q.ovf));
endmodule

// File: rtl/ctrl_mode_map.sv
module ctrl_mode_map
    import codec_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fir_sel,
    input  logic [1:0]  test_sel,
    input  logic [1:0]  path_sel,
    input  logic        flag_src,
    input  logic        flag_val,
    input  logic        sec_interval,
    output logic        fir_bypass,
    output logic        loop_analog,
    output logic        loop_digital,
    output logic        evt_mon,
    output logic        adc_off,
    output logic        dac_off,
    output logic        soft_pd,
    output logic        flag_pin
);
    always_comb begin
        fir_bypass   = fir_sel;
        loop_analog  = (test_sel == 2'b01);
        loop_digital = (test_sel == 2'b10);
        evt_mon      = (test_sel == 2'b11);
        adc_off      = (path_sel == 2'b01);
        dac_off      = (path_sel == 2'b10);
        soft_pd      = (path_sel == 2'b11);
        flag_pin     = flag_src ? flag_val : sec_interval;
    end

    assert_test_mode_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loop_analog, loop_digital, evt_mon}));

    assert_path_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adc_off, dac_off, soft_pd}));

    assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_src |-> flag_pin == sec_interval);
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
    import codec_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_pd_n,
    input  logic        is_master,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        ovf_event,
    input  logic        sec_interval,
    output logic        rsp_valid,
    output logic [15:0] rsp_word,
    output logic        fir_bypass,
    output logic        loop_analog,
    output logic        loop_digital,
    output logic        evt_mon,
    output logic        adc_off,
    output logic        dac_off,
    output logic        soft_pd,
    output logic        flag_pin,
    output logic        soft_rst
);
    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    regs_t             regs;

    ctrl_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .en        (hw_pd_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .data      (data)
    );

    ctrl_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (hw_pd_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (data),
        .ovf_event (ovf_event),
        .is_master (is_master),
        .regs      (regs),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .soft_rst  (soft_rst)
    );

    ctrl_mode_map u_modes (
        .clk          (clk),
        .rst_n        (rst_n),
        .fir_sel      (regs[REG_CTRL1][FIRBY_BIT]),
        .test_sel     (regs[REG_MODE][TEST_HI:TEST_LO]),
        .path_sel     (regs[REG_MODE][PATH_HI:PATH_LO]),
        .flag_src     (regs[REG_MODE][FSRC_BIT]),
        .flag_val     (regs[REG_MODE][FVAL_BIT]),
        .sec_interval (sec_interval),
        .fir_bypass   (fir_bypass),
        .loop_analog  (loop_analog),
        .loop_digital (loop_digital),
        .evt_mon      (evt_mon),
        .adc_off      (adc_off),
        .dac_off      (dac_off),
        .soft_pd      (soft_pd),
        .flag_pin     (flag_pin)
    );

    assert_noop_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && hw_pd_n && cmd_word[15:9] == 7'd0
            |=> !rsp_valid && !soft_rst && $stable(regs));
endmodule

// File: tb/codec_ctrl_regs_bench.sv
`timescale 1ns/1ps
module codec_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n, hw_pd_n, is_master, cmd_valid, ovf_event, sec_interval;
    logic [15:0] cmd_word;
    logic        rsp_valid, fir_bypass, loop_analog, loop_digital, evt_mon;
    logic        adc_off, dac_off, soft_pd, flag_pin, soft_rst;
    logic [15:0] rsp_word;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic done     = 1'b0;

    logic [7:0] m [0:7];
    logic       movf;

    always #2 clk = ~clk;

    codec_ctrl_regs u_codec_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .hw_pd_n(hw_pd_n), .is_master(is_master),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .ovf_event(ovf_event),
        .sec_interval(sec_interval), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .fir_bypass(fir_bypass), .loop_analog(loop_analog), .loop_digital(loop_digital),
        .evt_mon(evt_mon), .adc_off(adc_off), .dac_off(dac_off), .soft_pd(soft_pd),
        .flag_pin(flag_pin), .soft_rst(soft_rst)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        m[2] = 8'h20;
        movf = 1'b0;
    endtask

    task automatic check_modes();
        check("R6", "fir_bypass", 32'(fir_bypass), 32'(m[1][2]));
        check("R6", "loop_analog", 32'(loop_analog), 32'(m[3][7:6] == 2'b01));
        check("R6", "loop_digital", 32'(loop_digital), 32'(m[3][7:6] == 2'b10));
        check("R7", "evt_mon", 32'(evt_mon), 32'(m[3][7:6] == 2'b11));
        check("R8", "adc_off", 32'(adc_off), 32'(m[3][2:1] == 2'b01));
        check("R8", "dac_off", 32'(dac_off), 32'(m[3][2:1] == 2'b10));
        check("R8", "soft_pd", 32'(soft_pd), 32'(m[3][2:1] == 2'b11));
        check("R9", "flag_pin", 32'(flag_pin),
              32'(m[3][4] ? m[3][3] : sec_interval));
    endtask

    // drive one cycle of stimulus, update the model, check after the edge
    task automatic apply(input logic [15:0] w, input logic cv, input logic ev,
                         input string req);
        logic        exp_valid, exp_srst, rd;
        logic [2:0]  a;
        logic [7:0]  d, rv;
        logic [15:0] exp_word;
        cmd_valid = cv; cmd_word = w; ovf_event = ev;
        @(negedge clk);
        cmd_valid = 1'b0; ovf_event = 1'b0;
        exp_valid = 1'b0; exp_srst = 1'b0; exp_word = '0;
        rd = w[12]; a = w[11:9]; d = w[7:0];
        if (hw_pd_n) begin
            if (cv && w[15:9] != 7'd0 && rd) begin
                rv = (a >= 3'd1 && a <= 3'd4) ? m[a] : 8'h00;
                if (a == 3'd1) rv[7] = movf;
                exp_valid = 1'b1;
                exp_word  = {is_master, 2'b00, 1'b1, a, 1'b0, rv};
                if (a == 3'd1) movf = ev;
                else if (ev) movf = 1'b1;
                if (m[3][7:6] == 2'b11) m[3][7:6] = 2'b00;
            end else begin
                if (ev) movf = 1'b1;
                if (cv && w[15:9] != 7'd0) begin
                    if (a == 3'd1 && d[3]) begin
                        model_defaults();
                        exp_srst = 1'b1;
                    end else if (a == 3'd1) begin
                        m[1] = d & 8'h77;
                    end else if (a >= 3'd2 && a <= 3'd4) begin
                        m[a] = d;
                    end
                end
            end
        end
        check(req, "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
        if (exp_valid) check(req, "rsp_word", 32'(rsp_word), 32'(exp_word));
        check("R5", "soft_rst", 32'(soft_rst), 32'(exp_srst));
        check_modes();
    endtask

    function automatic logic [15:0] wr_word(input logic [2:0] a, input logic [7:0] d);
        return {3'b000, 1'b0, a, 1'b0, d};
    endfunction

    function automatic logic [15:0] rd_word(input logic [2:0] a);
        return {3'b000, 1'b1, a, 1'b0, 8'h00};
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; hw_pd_n = 1'b1; is_master = 1'b0; cmd_valid = 1'b0;
        cmd_word = '0; ovf_event = 1'b0; sec_interval = 1'b0;
        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: modes idle, no response, defaults readable (R2, R5)
        check("R2", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check_modes();
        for (int a = 0; a < 8; a++) apply(rd_word(3'(a)), 1'b1, 1'b0, "R2");

        // R1 R5 R6 R7 R8 R9: every value into every register, then read back
        for (int a = 1; a <= 4; a++) begin
            for (int d = 0; d < 256; d++) begin
                sec_interval = d[0] ^ d[5];
                is_master    = d[1];
                apply(wr_word(3'(a), 8'(d)), 1'b1, 1'b0, "R1");
                apply(rd_word(3'(a)), 1'b1, 1'b0, "R1");
            end
        end

        // R3: no-op words with bit 8 and data varied
        apply(wr_word(3'd4, 8'hA5), 1'b1, 1'b0, "R1");
        for (int d = 0; d < 512; d++) apply(16'(d), 1'b1, 1'b0, "R3");
        apply(rd_word(3'd4), 1'b1, 1'b0, "R3");

        // R4: sticky overflow, clear on read, event during read
        apply(16'h0000, 1'b0, 1'b1, "R4");
        apply(16'h0000, 1'b0, 1'b0, "R4");
        apply(wr_word(3'd1, 8'h84), 1'b1, 1'b0, "R4");
        apply(rd_word(3'd2), 1'b1, 1'b0, "R4");
        apply(rd_word(3'd1), 1'b1, 1'b0, "R4");
        apply(rd_word(3'd1), 1'b1, 1'b0, "R4");
        apply(16'h0000, 1'b0, 1'b1, "R4");
        apply(rd_word(3'd1), 1'b1, 1'b1, "R4");
        apply(rd_word(3'd1), 1'b1, 1'b0, "R4");
        apply(rd_word(3'd1), 1'b1, 1'b0, "R4");

        // R5: soft reset after non-default contents and overflow
        apply(wr_word(3'd4, 8'h3C), 1'b1, 1'b0, "R5");
        apply(wr_word(3'd2, 8'h07), 1'b1, 1'b0, "R5");
        apply(16'h0000, 1'b0, 1'b1, "R5");
        apply(wr_word(3'd1, 8'h08), 1'b1, 1'b0, "R5");
        for (int a = 1; a <= 4; a++) apply(rd_word(3'(a)), 1'b1, 1'b0, "R5");

        // R7: event-monitor ended by a read of another register
        apply(wr_word(3'd3, 8'hDA), 1'b1, 1'b0, "R7");
        apply(rd_word(3'd6), 1'b1, 1'b0, "R7");
        apply(rd_word(3'd3), 1'b1, 1'b0, "R7");

        // R8: writes accepted during software power-down
        apply(wr_word(3'd3, 8'h06), 1'b1, 1'b0, "R8");
        apply(wr_word(3'd4, 8'h5A), 1'b1, 1'b0, "R8");
        apply(rd_word(3'd4), 1'b1, 1'b0, "R8");

        // R10: hardware power-down freezes everything
        hw_pd_n = 1'b0;
        apply(wr_word(3'd4, 8'hFF), 1'b1, 1'b0, "R10");
        apply(wr_word(3'd1, 8'h08), 1'b1, 1'b0, "R10");
        apply(16'h0000, 1'b0, 1'b1, "R10");
        apply(rd_word(3'd4), 1'b1, 1'b0, "R10");
        hw_pd_n = 1'b1;
        apply(rd_word(3'd4), 1'b1, 1'b0, "R10");
        apply(rd_word(3'd1), 1'b1, 1'b0, "R10");
        apply(rd_word(3'd3), 1'b1, 1'b0, "R10");

        done = 1'b1;
        finish_run();
    end
endmodule